// File: doc/BRIEF.md
# Hash Context Save and Restore Port

This block is the register face of a multi-algorithm hash engine, reduced to the part software uses to park a running hash and pick it up later. Software picks an algorithm, optional keyed mode and data byte order through a configuration register, then reads or writes the engine's chaining words through a single auto-indexing window. A 64-bit count of bytes already hashed is exposed as two 32-bit halves. Together, the chaining words and the count are the complete context of a suspended hash.

The compression rounds are not modelled. A stub stands in for them. A start command with a legal algorithm holds the busy flag for a fixed number of cycles. When that time ends, the stub moves every active chaining word forward by one and adds one block length to the byte count. While busy is set, the context cannot be read or changed, so a save never captures a half-updated state.

Top module: `hash_ctx_port`

## Requirements
- R1: After reset the following values hold: busy is low, the configuration register reads zero (algorithm code 0), both length halves read zero and the window index is zero.
- R2: Each write to the chain window (address 1) stores one word at the current index and moves the index forward. Each read of the window returns the word at the current index and moves the index forward. Read data appears on `bus_rdata` one cycle after `bus_re`.
- R3: The number of chaining words is 16 for algorithm codes 2 and 3 and 8 for every other code. It appears on `state_words`. After the last word the index returns to zero.
- R4: `digest_words` gives the final digest length in words: 8 for code 0 (SHA-256), 7 for code 1 (SHA-224), 12 for code 2 (SHA-384), 16 for code 3 (SHA-512), 8 for code 4 (SM3) and 0 for codes 5 to 7.
- R5: Address 4 (length low) and address 5 (length high) can be written and read back.
- R6: Address 3 returns busy in bit 0 and zero in all other bits. Writing 1 to bit 0 of address 2 (command) with a legal algorithm sets busy for exactly BUSY_CYCLES cycles.
- R7: While busy is set, a window read returns zero and does not move the index. Writes to the window, the length halves and the configuration register are ignored.
- R8: An accepted configuration write, or any start command, sets the window index to zero.
- R9: Configuration register (address 0) layout: algorithm code in bits 18:16, keyed-mode enable in bit 22, data byte-order field in bits 31:26. A readback returns only these fields and zero in all other bits.
- R10: With an algorithm code above 4, a start command does not set busy.
- R11: When busy ends, each active chaining word has grown by one. The 64-bit length has grown by 64 for 8-word algorithms and by 128 for 16-word algorithms, with the carry passed into the high half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| busy | output | 1 | Stub engine running |
| state_words | output | 5 | Chaining words for current algorithm |
| digest_words | output | 5 | Digest words for current algorithm |

## Verification
A wrong window index is visible on the very next window read, because the word returned does not match the one stored there. A missing wrap shows up on the read that follows the last active word. A busy read that moves the index offsets every word of the next save by one position. A busy write that gets through damages the context, and this only shows once the stub finishes, when the saved words or the count come back off by more than one block. Mode decode faults show at once on `state_words` and `digest_words`, and on the length step taken at the end of the next busy period.

// File: rtl/hash_ctx_port.sv
module hash_ctx_port #(
  parameter int WMAX        = 16,
  parameter int BUSY_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        busy,
  output logic [4:0]  state_words,
  output logic [4:0]  digest_words
);
  localparam int IW = $clog2(WMAX);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [2:0] A_CFG = 3'd0, A_WIN = 3'd1, A_CMD = 3'd2,
                         A_STS = 3'd3, A_LLO = 3'd4, A_LHI = 3'd5;

  logic [2:0]    algo_q;
  logic          keyed_q;
  logic [5:0]    order_q;
  logic [31:0]   len_lo_q, len_hi_q;
  logic [31:0]   st_q [WMAX];
  logic [IW-1:0] idx_q;
  logic          busy_q;
  logic [CW-1:0] cnt_q;

  wire algo_ok = (algo_q <= 3'd4);
  wire wide    = (algo_q == 3'd2) || (algo_q == 3'd3);
  assign state_words = wide ? 5'd16 : 5'd8;
  assign busy = busy_q;

  always_comb begin
    case (algo_q)
      3'd0:    digest_words = 5'd8;
      3'd1:    digest_words = 5'd7;
      3'd2:    digest_words = 5'd12;
      3'd3:    digest_words = 5'd16;
      3'd4:    digest_words = 5'd8;
      default: digest_words = 5'd0;
    endcase
  end

  wire [IW-1:0] last_idx = IW'(state_words - 5'd1);
  wire [IW-1:0] idx_nxt  = (idx_q == last_idx) ? '0 : idx_q + 1'b1;
  wire cfg_wr  = bus_we && bus_addr == A_CFG && !busy_q;
  wire win_wr  = bus_we && bus_addr == A_WIN && !busy_q;
  wire win_rd  = bus_re && bus_addr == A_WIN && !busy_q;
  wire start   = bus_we && bus_addr == A_CMD && bus_wdata[0];
  wire go      = start && !busy_q && algo_ok;
  wire done    = busy_q && cnt_q == '0;
  wire [63:0] len_sum = {len_hi_q, len_lo_q} + (wide ? 64'd128 : 64'd64);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      algo_q <= '0; keyed_q <= 1'b0; order_q <= '0;
      len_lo_q <= '0; len_hi_q <= '0;
      idx_q <= '0; busy_q <= 1'b0; cnt_q <= '0;
      bus_rdata <= '0;
      for (int i = 0; i < WMAX; i++) st_q[i] <= '0;
    end else begin
      if (cfg_wr) begin
        algo_q  <= bus_wdata[18:16];
        keyed_q <= bus_wdata[22];
        order_q <= bus_wdata[31:26];
      end
      if (bus_we && !busy_q && bus_addr == A_LLO) len_lo_q <= bus_wdata;
      if (bus_we && !busy_q && bus_addr == A_LHI) len_hi_q <= bus_wdata;
      if (win_wr) st_q[idx_q] <= bus_wdata;

      if (cfg_wr || start)        idx_q <= '0;
      else if (win_wr || win_rd)  idx_q <= idx_nxt;

      if (go) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(BUSY_CYCLES - 1);
      end else if (done) begin
        busy_q   <= 1'b0;
        len_lo_q <= len_sum[31:0];
        len_hi_q <= len_sum[63:32];
        for (int i = 0; i < WMAX; i++)
          if (i < int'(state_words)) st_q[i] <= st_q[i] + 32'd1;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end

      if (bus_re) begin
        case (bus_addr)
          A_CFG:   bus_rdata <= {order_q, 3'b0, keyed_q, 3'b0, algo_q, 16'b0};
          A_WIN:   bus_rdata <= busy_q ? 32'd0 : st_q[idx_q];
          A_STS:   bus_rdata <= {31'b0, busy_q};
          A_LLO:   bus_rdata <= len_lo_q;
          A_LHI:   bus_rdata <= len_hi_q;
          default: bus_rdata <= 32'd0;
        endcase
      end
    end
  end
endmodule

module hash_ctx_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_we,
  input logic        bus_re,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        busy,
  input logic [4:0]  state_words,
  input logic [4:0]  digest_words,
  input logic [2:0]  algo,
  input logic [3:0]  idx
);
  // R6
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_we && bus_addr == 3'd2 && bus_wdata[0]));
  // R10
  bad_algo_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd2 && bus_wdata[0] && !busy && algo > 3'd4) |=> !busy);
  // R7
  busy_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == 3'd1 && busy) |=> bus_rdata == 32'd0);
  // R7
  busy_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(bus_we && bus_addr == 3'd2)) |=> $stable(idx));
  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, idx} < state_words);
  // R4
  digest_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digest_words <= state_words);
  // R8
  cfg_idx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 3'd0 && !busy) |=> idx == 4'd0);
endmodule

bind hash_ctx_port hash_ctx_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .busy(busy), .state_words(state_words), .digest_words(digest_words),
  .algo(algo_q), .idx(idx_q)
);

// File: tb/sim_hash_ctx_port.sv
`timescale 1ns/1ps
module sim_hash_ctx_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic busy;
  logic [4:0] state_words, digest_words;
  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  hash_ctx_port u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= bus_re;

  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(bus_rdata === e, t, bus_rdata, e);
    end
  end

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 100) begin n++; @(negedge clk); end
  endtask

  initial begin
    #500000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0, "R1 busy", 32'(busy), 0);
    chk(state_words === 5'd8, "R1 state_words", 32'(state_words), 8);
    rd(3'd0, 32'h0, "R1 cfg");
    rd(3'd4, 32'h0, "R1 len lo");
    rd(3'd5, 32'h0, "R1 len hi");
    rd(3'd1, 32'h0, "R1 window");
    rd(3'd3, 32'h0, "R6 status idle");
    // R9 field masking, R4 invalid code
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'hFC47_0000, "R9 cfg mask");
    chk(digest_words === 5'd0, "R4 invalid digest", 32'(digest_words), 0);
    // R10 invalid start
    wr(3'd2, 32'h1);
    chk(busy === 1'b0, "R10 no busy", 32'(busy), 0);
    // R2 R3 SHA-256 window
    wr(3'd0, 32'hA800_0000);
    rd(3'd0, 32'hA800_0000, "R9 cfg sha256");
    chk(digest_words === 5'd8 && state_words === 5'd8, "R4 sha256", 32'(digest_words), 8);
    for (int i = 0; i < 8; i++) wr(3'd1, 32'h1000 + i);
    for (int i = 0; i < 8; i++) rd(3'd1, 32'h1000 + i, "R2 window read");
    rd(3'd1, 32'h1000, "R3 wrap at 8");
    wr(3'd0, 32'hA800_0000);
    rd(3'd1, 32'h1000, "R8 cfg resets index");
    // R5 lengths
    wr(3'd4, 32'hFFFF_FFC0);
    wr(3'd5, 32'h5);
    rd(3'd4, 32'hFFFF_FFC0, "R5 len lo");
    rd(3'd5, 32'h5, "R5 len hi");
    // R6 R7 busy window
    wr(3'd2, 32'h1);
    chk(busy === 1'b1, "R6 busy set", 32'(busy), 1);
    rd(3'd1, 32'h0, "R7 busy read zero");
    wr(3'd1, 32'hDEAD);
    wr(3'd4, 32'h1234);
    wr(3'd0, 32'hA803_0000);
    wait_idle(n);
    rd(3'd0, 32'hA800_0000, "R7 cfg write ignored");
    // R11 step for 8-word algorithm with carry
    rd(3'd4, 32'h0, "R11 len lo carry");
    rd(3'd5, 32'h6, "R11 len hi carry");
    for (int i = 0; i < 8; i++) rd(3'd1, 32'h1001 + i, "R11 R7 R8 words after run");
    // SHA-512
    wr(3'd0, 32'hA803_0000);
    chk(state_words === 5'd16 && digest_words === 5'd16, "R3 R4 sha512", 32'(state_words), 16);
    for (int i = 0; i < 16; i++) wr(3'd1, 32'h2000 + i);
    for (int i = 0; i < 16; i++) rd(3'd1, 32'h2000 + i, "R2 wide read");
    rd(3'd1, 32'h2000, "R3 wrap at 16");
    wr(3'd2, 32'h1);
    rd(3'd3, 32'h1, "R6 status busy");
    wait_idle(n);
    chk(n == 3, "R6 busy length", 32'(n + 1), 4);
    rd(3'd4, 32'h80, "R11 wide len lo");
    rd(3'd5, 32'h6, "R11 wide len hi");
    for (int i = 0; i < 16; i++) rd(3'd1, 32'h2001 + i, "R11 wide words");
    // other algorithms
    wr(3'd0, 32'hA801_0000);
    chk(digest_words === 5'd7 && state_words === 5'd8, "R4 sha224", 32'(digest_words), 7);
    wr(3'd0, 32'hA802_0000);
    chk(digest_words === 5'd12 && state_words === 5'd16, "R4 sha384", 32'(digest_words), 12);
    wr(3'd0, 32'hA844_0000);
    chk(digest_words === 5'd8 && state_words === 5'd8, "R4 sm3", 32'(digest_words), 8);
    rd(3'd0, 32'hA844_0000, "R9 keyed bit");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule